// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block resolves where one interrupt message goes among a set of up to 32 local interrupt targets. A request carries an 8-bit destination, a physical/logical mode bit, a 3-bit delivery mode, a vector number and a trigger kind (edge or level). The targets' physical IDs, the top byte of their logical destination registers and their format nibbles arrive as flat input tables, along with a count of how many targets are registered. Only targets with an index below the count take part.

The unit builds a candidate mask in the clock that accepts the request. Fixed and external-interrupt modes keep the whole mask. Lowest-priority mode keeps one target, picked round-robin per vector. The remaining targets are then written one per clock, lowest index first. Each write sets the vector's bit in that target's request register and, for level trigger, in its trigger-mode register. A target consumes a vector through the clear port. `ready_o` is low while writes are outstanding. Error and warning pulses mark bad addressing, unsupported modes and repeated level requests.

Top module: `irq_dest_match`

## Requirements
- R1: In physical mode (`req_logical_i`=0) only the lowest-indexed registered target whose physical ID equals the destination is selected. If none matches, nothing is selected. Targets at or above `tgt_count_i` never match.
- R2: In logical mode a destination of 0 selects no target and raises no error.
- R3: A target with format nibble 4'hF uses flat logical matching: it matches when (destination AND its logical byte) is nonzero.
- R4: A target with format nibble 4'h0 uses cluster logical matching: logical byte bits 7:4 equal destination bits 7:4, and (logical byte bits 3:0 AND destination bits 3:0) is nonzero.
- R5: In logical mode with a nonzero destination, a registered target with any other format nibble matches nothing. `err_o` pulses for one cycle, one clock after acceptance. Other targets still match normally.
- R6: Delivery modes 2 (SMI), 3 (reserved), 4 (NMI), 5 (INIT) and 6 (startup) deliver nothing. `err_o` pulses one clock after acceptance.
- R7: Modes 0 (fixed) and 7 (external) write every selected target, one per clock, in ascending index order. The first write lands two edges after acceptance. `ready_o` is low until the last write.
- R8: Mode 1 (lowest priority) writes exactly one selected target. It is the first selected index after the one last chosen for the same vector, wrapping, and the search starts at index 0 after reset.
- R9: A write sets request bit [target][vector]. A level write (`req_level_i`=1) also sets trigger bit [target][vector]. An edge write leaves the trigger bits unchanged, and trigger bits never clear.
- R10: `warn_o` pulses in the cycle after a level write whose request bit was already set.
- R11: `clr_valid_i` clears request bit [`clr_tgt_i`][`clr_vec_i`] at the next edge. A write to the same bit in the same cycle wins.
- R12: After reset all request and trigger bits are 0, `ready_o` is 1 and `err_o`/`warn_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present; taken when `ready_o` is 1 |
| req_dest_i | input | 8 | Destination ID |
| req_logical_i | input | 1 | 1 = logical addressing, 0 = physical |
| req_mode_i | input | 3 | Delivery mode code |
| req_vec_i | input | $clog2(NV) | Vector number |
| req_level_i | input | 1 | 1 = level trigger, 0 = edge |
| tgt_count_i | input | $clog2(N+1) | Number of registered targets |
| tgt_phys_id_i | input | N*8 | Physical ID per target, target i at bits 8i+7:8i |
| tgt_ldr_i | input | N*8 | Logical destination byte per target |
| tgt_fmt_i | input | N*4 | Format nibble per target |
| clr_valid_i | input | 1 | Clear one request bit |
| clr_tgt_i | input | $clog2(N) | Target of the clear |
| clr_vec_i | input | $clog2(NV) | Vector of the clear |
| ready_o | output | 1 | No writes outstanding; a request can be taken |
| err_o | output | 1 | Addressing or mode error pulse |
| warn_o | output | 1 | Repeated level request pulse |
| irr_o | output | N*NV | Request bits, target t vector v at bit t*NV+v |
| tmr_o | output | N*NV | Trigger-mode bits, same layout |

## Verification
The assertions assume that the driver changes the request and clear inputs only between edges and holds `req_valid_i` to a known value from reset onward. They also assume that trigger bits are only ever set, because the block has no path to clear them. The stimulus drives every input on the falling edge and offers a request only while `ready_o` is high. The table inputs change only while the unit is idle, so a pending burst always sees the table it was decoded from.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    localparam logic [3:0] FMT_FLAT    = 4'hF;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;
    localparam int unsigned DEST_W     = 8;
endpackage

// File: rtl/irq_dest_decode.sv
module irq_dest_decode
    import irq_dest_pkg::*;
#(
    parameter int unsigned N  = 32,
    localparam int unsigned CW = $clog2(N + 1)
) (
    input  logic [DEST_W-1:0]           dest_i,
    input  logic                        logical_i,
    input  logic [2:0]                  mode_i,
    input  logic [CW-1:0]               count_i,
    input  logic [N-1:0][DEST_W-1:0]    phys_id_i,
    input  logic [N-1:0][DEST_W-1:0]    ldr_i,
    input  logic [N-1:0][3:0]           fmt_i,
    output logic [N-1:0]                mask_o,
    output logic                        err_o
);
    logic [N-1:0] phys_mask;
    logic [N-1:0] log_mask;
    logic [N-1:0] bad_fmt;
    logic         unsup;

    always_comb begin
        logic found;
        found     = 1'b0;
        phys_mask = '0;
        log_mask  = '0;
        bad_fmt   = '0;
        for (int i = 0; i < N; i++) begin
            if (i < int'(count_i)) begin
                if (!found && phys_id_i[i] == dest_i) begin
                    phys_mask[i] = 1'b1;
                    found        = 1'b1;
                end
                if (dest_i != '0) begin
                    unique case (fmt_i[i])
                        FMT_FLAT:
                            log_mask[i] = |(dest_i & ldr_i[i]);
                        FMT_CLUSTER:
                            log_mask[i] = (ldr_i[i][7:4] == dest_i[7:4]) &&
                                          (|(ldr_i[i][3:0] & dest_i[3:0]));
                        default:
                            bad_fmt[i] = 1'b1;
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (dmode_e'(mode_i))
            DM_FIXED, DM_LOWPRI, DM_EXTINT: unsup = 1'b0;
            default:                        unsup = 1'b1;
        endcase
    end

    assign mask_o = logical_i ? log_mask : phys_mask;
    assign err_o  = unsup || (logical_i && (|bad_fmt));
endmodule

// File: rtl/irq_dest_rr_pick.sv
module irq_dest_rr_pick #(
    parameter int unsigned N  = 32,
    localparam int unsigned TW = $clog2(N)
) (
    input  logic [N-1:0]  mask_i,
    input  logic [TW-1:0] last_i,
    output logic [TW-1:0] pick_o,
    output logic          any_o
);
    always_comb begin
        pick_o = '0;
        any_o  = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last_i) + k) % N;
            if (!any_o && mask_i[j]) begin
                pick_o = TW'(j);
                any_o  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
    import irq_dest_pkg::*;
#(
    parameter int unsigned N  = 32,
    parameter int unsigned NV = 16,
    localparam int unsigned TW = $clog2(N),
    localparam int unsigned VW = $clog2(NV),
    localparam int unsigned CW = $clog2(N + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_valid_i,
    input  logic [7:0]         req_dest_i,
    input  logic               req_logical_i,
    input  logic [2:0]         req_mode_i,
    input  logic [VW-1:0]      req_vec_i,
    input  logic               req_level_i,
    input  logic [CW-1:0]      tgt_count_i,
    input  logic [N*8-1:0]     tgt_phys_id_i,
    input  logic [N*8-1:0]     tgt_ldr_i,
    input  logic [N*4-1:0]     tgt_fmt_i,
    input  logic               clr_valid_i,
    input  logic [TW-1:0]      clr_tgt_i,
    input  logic [VW-1:0]      clr_vec_i,
    output logic               ready_o,
    output logic               err_o,
    output logic               warn_o,
    output logic [N*NV-1:0]    irr_o,
    output logic [N*NV-1:0]    tmr_o
);
    typedef struct packed {
        logic [N-1:0]           pend;
        logic [VW-1:0]          vec;
        logic                   lvl;
        logic [N-1:0][NV-1:0]   irr;
        logic [N-1:0][NV-1:0]   tmr;
        logic [NV-1:0][TW-1:0]  rr;
        logic                   err;
        logic                   warn;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]  dec_mask;
    logic          dec_err;
    logic [TW-1:0] pick_idx;
    logic          pick_any;
    logic [TW-1:0] wr_t;
    logic          wr_any;
    logic          accept;

    irq_dest_decode #(.N(N)) u_decode (
        .dest_i    (req_dest_i),
        .logical_i (req_logical_i),
        .mode_i    (req_mode_i),
        .count_i   (tgt_count_i),
        .phys_id_i (tgt_phys_id_i),
        .ldr_i     (tgt_ldr_i),
        .fmt_i     (tgt_fmt_i),
        .mask_o    (dec_mask),
        .err_o     (dec_err)
    );

    irq_dest_rr_pick #(.N(N)) u_pick (
        .mask_i (dec_mask),
        .last_i (st_q.rr[req_vec_i]),
        .pick_o (pick_idx),
        .any_o  (pick_any)
    );

    always_comb begin
        wr_t   = '0;
        wr_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (st_q.pend[i]) begin
                wr_t   = TW'(i);
                wr_any = 1'b1;
            end
        end
    end

    assign ready_o = (st_q.pend == '0);
    assign accept  = req_valid_i && ready_o;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        st_d.warn = 1'b0;
        if (wr_any) begin
            st_d.warn = st_q.lvl && st_q.irr[wr_t][st_q.vec];
        end
        if (clr_valid_i) begin
            st_d.irr[clr_tgt_i][clr_vec_i] = 1'b0;
        end
        if (wr_any) begin
            st_d.irr[wr_t][st_q.vec] = 1'b1;
            if (st_q.lvl) begin
                st_d.tmr[wr_t][st_q.vec] = 1'b1;
            end
            st_d.pend[wr_t] = 1'b0;
        end
        if (accept) begin
            st_d.vec = req_vec_i;
            st_d.lvl = req_level_i;
            st_d.err = dec_err;
            unique case (dmode_e'(req_mode_i))
                DM_FIXED, DM_EXTINT: st_d.pend = dec_mask;
                DM_LOWPRI: begin
                    if (pick_any) begin
                        st_d.pend           = '0;
                        st_d.pend[pick_idx] = 1'b1;
                        st_d.rr[req_vec_i]  = pick_idx;
                    end
                end
                default: st_d.pend = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.rr   <= {NV{TW'(N - 1)}};
        end else begin
            st_q      <= st_d;
        end
    end

    assign err_o  = st_q.err;
    assign warn_o = st_q.warn;
    assign irr_o  = st_q.irr;
    assign tmr_o  = st_q.tmr;
endmodule

// File: rtl/irq_dest_match_chk.sv
module irq_dest_match_chk #(
    parameter int unsigned N  = 32,
    parameter int unsigned NV = 16
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            req_valid_i,
    input logic [7:0]      req_dest_i,
    input logic            req_logical_i,
    input logic [2:0]      req_mode_i,
    input logic            ready_o,
    input logic            err_o,
    input logic            warn_o,
    input logic [N*NV-1:0] irr_o,
    input logic [N*NV-1:0] tmr_o
);
    logic acc;
    logic unsup;
    assign acc   = req_valid_i && ready_o;
    assign unsup = (req_mode_i != 3'd0) && (req_mode_i != 3'd1) && (req_mode_i != 3'd7);

    // R6: unsupported mode gives an error and leaves nothing pending
    assert_unsup_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && unsup) |=> (err_o && ready_o));

    // R2: logical destination zero selects nothing
    assert_zero_dest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc && req_logical_i && req_dest_i == 8'd0) |=> ready_o);

    // R8: lowest priority finishes with a single write
    assert_lowpri_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(acc && req_mode_i == 3'd1) && !ready_o) |=> ready_o);

    // R7: at most one new request bit per clock
    assert_one_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(irr_o & ~$past(irr_o)) <= 1);

    // R7: nothing is written after an idle cycle
    assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ready_o) |-> ((irr_o & ~$past(irr_o)) == '0));

    // R9: trigger bits never clear
    assert_tmr_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(tmr_o) & ~tmr_o) == '0);

    // R10: a warning only follows a write cycle
    assert_warn_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warn_o |-> !$past(ready_o));
endmodule

bind irq_dest_match irq_dest_match_chk #(.N(N), .NV(NV)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_dest_i    (req_dest_i),
    .req_logical_i (req_logical_i),
    .req_mode_i    (req_mode_i),
    .ready_o       (ready_o),
    .err_o         (err_o),
    .warn_o        (warn_o),
    .irr_o         (irr_o),
    .tmr_o         (tmr_o)
);

// File: tb/irq_dest_match_tb_top.sv
`timescale 1ns/1ps
module irq_dest_match_tb_top;
    localparam int N  = 32;
    localparam int NV = 16;
    localparam int TW = $clog2(N);
    localparam int VW = $clog2(NV);
    localparam int CW = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_v = 1'b0;
    logic [7:0]        req_dest = '0;
    logic              req_log = 1'b0;
    logic [2:0]        req_mode = '0;
    logic [VW-1:0]     req_vec = '0;
    logic              req_lvl = 1'b0;
    logic [CW-1:0]     cnt = '0;
    logic [N*8-1:0]    pid = '0;
    logic [N*8-1:0]    ldr = '0;
    logic [N*4-1:0]    fmt = '0;
    logic              clr_v = 1'b0;
    logic [TW-1:0]     clr_t = '0;
    logic [VW-1:0]     clr_vec = '0;
    logic              ready, err, warn;
    logic [N*NV-1:0]   irr, tmr;

    always #5 clk = ~clk;

    irq_dest_match #(.N(N), .NV(NV)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_dest_i(req_dest),
        .req_logical_i(req_log), .req_mode_i(req_mode), .req_vec_i(req_vec),
        .req_level_i(req_lvl), .tgt_count_i(cnt), .tgt_phys_id_i(pid),
        .tgt_ldr_i(ldr), .tgt_fmt_i(fmt), .clr_valid_i(clr_v), .clr_tgt_i(clr_t),
        .clr_vec_i(clr_vec), .ready_o(ready), .err_o(err), .warn_o(warn),
        .irr_o(irr), .tmr_o(tmr)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R12";

    // behavioural reference model
    int          q[$];
    bit [N*NV-1:0] m_irr, m_tmr;
    bit          m_err, m_warn, m_rdy;
    int          m_vec;
    bit          m_lvl;
    int          m_rr[NV];

    task automatic model_accept();
        bit [N-1:0] hit;
        bit bad, unsup;
        int d;
        hit = '0; bad = 0;
        d = int'(req_dest);
        for (int i = 0; i < int'(cnt); i++) begin
            int id, lb, fn;
            id = int'(pid[i*8 +: 8]); lb = int'(ldr[i*8 +: 8]); fn = int'(fmt[i*4 +: 4]);
            if (!req_log) begin
                if (id == d && hit == 0) hit[i] = 1;
            end else if (d != 0) begin
                if (fn == 15) hit[i] = ((d & lb) != 0);
                else if (fn == 0) hit[i] = ((lb / 16) == (d / 16)) && (((lb % 16) & (d % 16)) != 0);
                else bad = 1;
            end
        end
        unsup = !(req_mode == 0 || req_mode == 1 || req_mode == 7);
        m_err = unsup || (req_log && bad);
        m_vec = int'(req_vec); m_lvl = req_lvl;
        if (req_mode == 0 || req_mode == 7) begin
            for (int i = 0; i < N; i++) if (hit[i]) q.push_back(i);
        end else if (req_mode == 1) begin
            for (int k = 1; k <= N; k++) begin
                int j;
                j = (m_rr[m_vec] + k) % N;
                if (hit[j] && q.size() == 0) begin q.push_back(j); m_rr[m_vec] = j; end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_irr = '0; m_tmr = '0; m_err = 0; m_warn = 0; m_rdy = 1;
            m_vec = 0; m_lvl = 0;
            for (int v = 0; v < NV; v++) m_rr[v] = N - 1;
        end else begin
            bit pre; int t;
            pre = (q.size() == 0);
            m_err = 0; m_warn = 0; t = 0;
            if (!pre) begin t = q.pop_front(); m_warn = m_lvl && m_irr[t*NV + m_vec]; end
            if (clr_v) m_irr[int'(clr_t)*NV + int'(clr_vec)] = 0;
            if (!pre) begin
                m_irr[t*NV + m_vec] = 1;
                if (m_lvl) m_tmr[t*NV + m_vec] = 1;
            end
            if (req_v && pre) model_accept();
            m_rdy = (q.size() == 0);
        end
    end

    task automatic chk(string what, logic [N*NV-1:0] act, logic [N*NV-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("ready", {{(N*NV-1){1'b0}}, ready}, {{(N*NV-1){1'b0}}, m_rdy});
            chk("err",   {{(N*NV-1){1'b0}}, err},   {{(N*NV-1){1'b0}}, m_err});
            chk("warn",  {{(N*NV-1){1'b0}}, warn},  {{(N*NV-1){1'b0}}, m_warn});
            chk("irr", irr, m_irr);
            chk("tmr", tmr, m_tmr);
        end
    end

    task automatic send(bit lg, int dest, int mode, int vec, bit lvl);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_v = 1; req_log = lg; req_dest = 8'(dest); req_mode = 3'(mode);
        req_vec = VW'(vec); req_lvl = lvl;
        @(negedge clk);
        req_v = 0;
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear(int t, int v);
        @(negedge clk);
        clr_v = 1; clr_t = TW'(t); clr_vec = VW'(v);
        @(negedge clk);
        clr_v = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        cnt = CW'(8);
        for (int i = 0; i < N; i++) begin
            pid[i*8 +: 8] = 8'(8'h10 + i);
            fmt[i*4 +: 4] = 4'hF;
        end
        pid[5*8 +: 8]  = 8'h12;            // same ID as target 2
        pid[10*8 +: 8] = 8'h40;            // unregistered target
        ldr[0*8 +: 8] = 8'h01; ldr[1*8 +: 8] = 8'h02; ldr[2*8 +: 8] = 8'h04;
        ldr[3*8 +: 8] = 8'h0C; ldr[4*8 +: 8] = 8'h31; ldr[5*8 +: 8] = 8'h32;
        ldr[6*8 +: 8] = 8'h01; ldr[7*8 +: 8] = 8'h80;
        fmt[4*4 +: 4] = 4'h0; fmt[5*4 +: 4] = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        tag = "R12";
        chk("reset-ready", {{(N*NV-1){1'b0}}, ready}, {{(N*NV-1){1'b0}}, 1'b1});
        chk("reset-irr", irr, '0);
        tag = "R1";  send(0, 8'h12, 0, 1, 1);
        tag = "R1";  send(0, 8'h40, 0, 2, 0);
        tag = "R3";  send(1, 8'h0C, 0, 3, 0);
        tag = "R4";  send(1, 8'h33, 0, 4, 1);
        tag = "R2";  send(1, 8'h00, 0, 6, 0);
        tag = "R5";  fmt[6*4 +: 4] = 4'h5; send(1, 8'h01, 0, 8, 0);
        fmt[6*4 +: 4] = 4'hF;
        tag = "R6";  send(0, 8'h10, 4, 9, 0);
        tag = "R6";  send(1, 8'h03, 2, 9, 0);
        tag = "R8";  for (int r = 0; r < 4; r++) send(1, 8'h03, 1, 5, 0);
        tag = "R7";  send(1, 8'hFF, 7, 10, 0);
        tag = "R10"; send(0, 8'h10, 0, 7, 1); send(0, 8'h10, 0, 7, 1);
        tag = "R11"; clear(0, 7); send(0, 8'h10, 0, 7, 1);
        tag = "R9";  send(0, 8'h11, 0, 11, 0);
        tag = "R7";
        for (int r = 0; r < 300; r++) begin
            int dsel;
            dsel = int'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0) clear(int'($urandom_range(0, 7)), int'($urandom_range(0, NV-1)));
            send(bit'($urandom_range(0, 1)),
                 (dsel == 0) ? int'($urandom_range(0, 255)) : (dsel == 1 ? 16 + int'($urandom_range(0, 9)) : int'($urandom_range(0, 63))),
                 (dsel == 3) ? 1 : int'($urandom_range(0, 7)),
                 int'($urandom_range(0, NV-1)), bit'($urandom_range(0, 1)));
        end
        repeat (4) @(negedge clk);
        summary();
    end
endmodule